// File: doc/BRIEF.md
# Segment-Register Memory Bank Mapper

This block translates the 16-bit address of a small processor into an address in a larger physical space that holds both a read-only program store and a read-write data store. The CPU space is split into four 16 KB windows, picked by the top two address bits. Each window has its own 8-bit segment register, and the value in that register decides which physical block the window shows. Software loads a segment register by writing an I/O port. The mapper answers every access in the same cycle. It gives the physical address, a select for the read-only store or the read-write store, a write enable for the read-write store, and a flag for accesses that land on no memory. The memories themselves sit outside the block. When the unmapped flag is raised, the bus logic must return 0xFF on reads.

Segment values from 0x20 upward point at read-write blocks, and values below 0x20 point at read-only blocks. The lowest 8 KB of window 0 does not follow the segment register. An external control bit places the first read-only block or the first read-write block there. The control bit is low out of reset, so the overlay shows the read-only block.

Top module: `seg_bank_mapper`

## Requirements
- R1: CPU address bits 15..14 select window n (0 to 3), and window n is translated through segment register n. Register n is loaded by an I/O write to port 0xD0+n. An access made in the same cycle as that write still uses the old value. Accesses from the next cycle onward use the new value.
- R2: A segment value v with 0x20 <= v < 0xA0 maps to read-write block b = v-0x20. The physical address is {b[6:0], addr[13:0]} (21 bits). `ram_sel` is high on a read or a write. `ram_we` is high on a write only.
- R3: A segment value of 0xA0 or more names read-write block 128 or higher, which is unmapped. On any access, `unmapped` is high, `rom_sel`, `ram_sel` and `ram_we` are low, and `phys_addr` is 0.
- R4: A segment value v < 0x20 maps to read-only block v AND 7. The physical address is {4'b0, v[2:0], addr[13:0]}, and `rom_sel` is high on reads.
- R5: A write to a window that shows the read-only store is dropped: `ram_we`, `ram_sel`, `rom_sel` and `unmapped` all stay low.
- R6: For addresses 0x0000-0x1FFF, the result does not depend on segment register 0. With `ovl_ram` low, the access goes read-only to physical address addr[13:0] in the read-only store. With `ovl_ram` high, it goes read-write to physical address addr[13:0] in the read-write store.
- R7: Addresses 0x2000-0x3FFF always follow segment register 0, whatever the level of `ovl_ram`.
- R8: Synchronous reset clears all four segment registers, so every window reads read-only block 0.
- R9: With neither `cpu_rd` nor `cpu_wr` high, `rom_sel`, `ram_sel`, `ram_we` and `unmapped` are all low.
- R10: I/O writes to ports other than 0xD0-0xD3 leave every segment register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number (low byte) |
| io_data | input | 8 | I/O write data |
| ovl_ram | input | 1 | Low-8 KB overlay: 0 = read-only block 0, 1 = read-write block 0 |
| phys_addr | output | 21 | Physical address {block, offset} |
| rom_sel | output | 1 | Read-only store selected |
| ram_sel | output | 1 | Read-write store selected |
| ram_we | output | 1 | Write enable to read-write store |
| unmapped | output | 1 | Access hits no memory; reads must return 0xFF |

## Verification
Two things can land in the same cycle: a segment-register load and a CPU access through that same register. The bench sets up this collision by raising the port write together with a read of the target window. In that cycle it expects the translation of the old value, and after the clock edge it expects the new one. Overlay changes are checked the same way, at the boundary between 0x1FFF and 0x2000. The bench sweeps all 256 segment values on every window, for both reads and writes, and compares each result with a model computed from the requirements.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int ADDR_W    = 16;
    localparam int WIN_N     = 4;
    localparam int WIN_SEL_W = $clog2(WIN_N);
    localparam int OFS_W     = ADDR_W - WIN_SEL_W;
    localparam int SEG_W     = 8;
    localparam int RAM_BLK_W = 7;
    localparam int ROM_BLK_W = 3;
    localparam int PHYS_W    = RAM_BLK_W + OFS_W;
    localparam logic [SEG_W-1:0] RAM_FIRST = 8'h20;
    localparam logic [7:0]       SEG_PORT0 = 8'hD0;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_VOID = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e                 tgt;
        logic [RAM_BLK_W-1:0] blk;
    } map_t;

    function automatic map_t seg_decode(input logic [SEG_W-1:0] seg);
        map_t             m;
        logic [SEG_W-1:0] idx;
        m.tgt = TGT_NONE;
        m.blk = '0;
        if (seg >= RAM_FIRST) begin
            idx = seg - RAM_FIRST;
            if ((idx >> RAM_BLK_W) != '0) begin
                m.tgt = TGT_VOID;
            end else begin
                m.tgt = TGT_RAM;
                m.blk = idx[RAM_BLK_W-1:0];
            end
        end else begin
            m.tgt = TGT_ROM;
            m.blk = {{(RAM_BLK_W-ROM_BLK_W){1'b0}}, seg[ROM_BLK_W-1:0]};
        end
        return m;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import mapper_pkg::*;
#(
    parameter int               N     = WIN_N,
    parameter int               W     = SEG_W,
    parameter logic [7:0]       PORT0 = SEG_PORT0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic [7:0]          io_port,
    input  logic [W-1:0]        io_data,
    output logic [N-1:0][W-1:0] seg_q
);

    logic port_hit_any;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam logic [7:0] MY_PORT = PORT0 + 8'(i);

        assign hit[i] = io_wr && (io_port == MY_PORT);

        always_ff @(posedge clk) begin
            if (rst) begin
                seg_q[i] <= '0;
            end else if (hit[i]) begin
                seg_q[i] <= io_data;
            end
        end

        assert_seg_load_R1: assert property (@(posedge clk) disable iff (rst)
            (io_wr && io_port == MY_PORT) |=> (seg_q[i] == $past(io_data)));
    end

    assign port_hit_any = |hit;

    assert_foreign_port_R10: assert property (@(posedge clk) disable iff (rst)
        (io_wr && (io_port < PORT0 || io_port >= PORT0 + 8'(N))) |=> $stable(seg_q));

    assert_hit_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        port_hit_any |-> $onehot0(hit));

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import mapper_pkg::*;
#(
    parameter int N = WIN_N,
    parameter int W = SEG_W
) (
    input  logic [N-1:0][W-1:0] seg_q,
    output map_t [N-1:0]        maps
);

    for (genvar i = 0; i < N; i++) begin : g_dec
        always_comb begin
            maps[i] = seg_decode(seg_q[i]);
        end
    end

endmodule

// File: rtl/window_mux.sv
module window_mux
    import mapper_pkg::*;
#(
    parameter int N     = WIN_N,
    parameter int SEL_W = WIN_SEL_W
) (
    input  map_t [N-1:0]     maps,
    input  logic [SEL_W-1:0] win_sel,
    input  logic             upper_half,
    input  logic             ovl_ram,
    output map_t             map_out
);

    logic in_overlay;

    assign in_overlay = (win_sel == '0) && !upper_half;

    always_comb begin
        map_out = maps[win_sel];
        if (in_overlay) begin
            map_out.tgt = ovl_ram ? TGT_RAM : TGT_ROM;
            map_out.blk = '0;
        end
    end

endmodule

// File: rtl/seg_bank_mapper.sv
module seg_bank_mapper
    import mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              io_wr,
    input  logic [7:0]        io_port,
    input  logic [SEG_W-1:0]  io_data,
    input  logic              ovl_ram,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              ram_we,
    output logic              unmapped
);

    logic [WIN_N-1:0][SEG_W-1:0] seg_q;
    map_t [WIN_N-1:0]            maps;
    map_t                        cur;
    logic                        access;

    seg_regfile #(.N(WIN_N), .W(SEG_W), .PORT0(SEG_PORT0)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_port (io_port),
        .io_data (io_data),
        .seg_q   (seg_q)
    );

    seg_decoder #(.N(WIN_N), .W(SEG_W)) u_dec (
        .seg_q (seg_q),
        .maps  (maps)
    );

    window_mux #(.N(WIN_N), .SEL_W(WIN_SEL_W)) u_mux (
        .maps       (maps),
        .win_sel    (cpu_addr[ADDR_W-1 -: WIN_SEL_W]),
        .upper_half (cpu_addr[OFS_W-1]),
        .ovl_ram    (ovl_ram),
        .map_out    (cur)
    );

    assign access = cpu_rd || cpu_wr;

    always_comb begin
        rom_sel  = cpu_rd && (cur.tgt == TGT_ROM);
        ram_sel  = access && (cur.tgt == TGT_RAM);
        ram_we   = cpu_wr && (cur.tgt == TGT_RAM);
        unmapped = access && (cur.tgt == TGT_VOID);
        if (cur.tgt == TGT_ROM || cur.tgt == TGT_RAM) begin
            phys_addr = {cur.blk, cpu_addr[OFS_W-1:0]};
        end else begin
            phys_addr = '0;
        end
    end

    assert_single_target_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, ram_sel, unmapped}));

    assert_void_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (!ram_we && phys_addr == '0));

    assert_we_needs_ram_R5: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_sel && cpu_wr));

    assert_ram_write_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && ram_sel) |-> ram_we);

    assert_overlay_rom_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr[ADDR_W-1:OFS_W-1] == '0 && !ovl_ram)
            |-> (rom_sel && phys_addr == PHYS_W'(cpu_addr)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd && !cpu_wr) |-> (!rom_sel && !ram_sel && !ram_we && !unmapped));

endmodule

// File: tb/seg_bank_mapper_test.sv
`timescale 1ns/1ps
module seg_bank_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic [7:0]  io_data = '0;
    logic        ovl_ram = 1'b0;
    logic [20:0] phys_addr;
    logic        rom_sel, ram_sel, ram_we, unmapped;

    int tests = 0;
    int fails = 0;
    logic [7:0] shadow [4];

    always #5 clk = ~clk;

    seg_bank_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .io_wr(io_wr), .io_port(io_port), .io_data(io_data), .ovl_ram(ovl_ram),
        .phys_addr(phys_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .ram_we(ram_we), .unmapped(unmapped)
    );

    // {phys[20:0], rom_sel, ram_sel, ram_we, unmapped}
    function automatic logic [24:0] model(input logic [7:0] seg, input logic [15:0] a,
                                          input logic ovl, input logic rd, input logic wr);
        int kind; // 0 rom, 1 ram, 2 void
        int blk;
        logic [20:0] pa;
        if (a < 16'h2000) begin
            kind = ovl ? 1 : 0;
            blk = 0;
        end else if (seg >= 8'h20) begin
            blk = int'(seg) - 32;
            kind = (blk >= 128) ? 2 : 1;
        end else begin
            kind = 0;
            blk = int'(seg) % 8;
        end
        pa = (kind == 2) ? 21'd0 : 21'(blk * 16384 + int'(a) % 16384);
        return {pa, rd && kind == 0, (rd || wr) && kind == 1, wr && kind == 1,
                (rd || wr) && kind == 2};
    endfunction

    task automatic check(input string req, input logic [24:0] got, input logic [24:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic rd, input logic wr);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #1;
        check(req, {phys_addr, rom_sel, ram_sel, ram_we, unmapped},
              model(shadow[a[15:14]], a, ovl_ram, rd, wr));
    endtask

    task automatic load_seg(input logic [7:0] port, input logic [7:0] val);
        @(negedge clk);
        io_wr = 1'b1; io_port = port; io_data = val;
        @(negedge clk);
        io_wr = 1'b0;
        if (port >= 8'hD0 && port <= 8'hD3) shadow[port[1:0]] = val;
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset state, every window read-only block 0
        for (int w = 0; w < 4; w++) probe("R8", 16'(w * 16384 + 16'h2345), 1'b1, 1'b0);
        // R9: idle produces no select
        probe("R9", 16'h8123, 1'b0, 1'b0);

        // Sweep: R1 R2 R3 R4 R5 R7 on every window
        for (int w = 0; w < 4; w++) begin
            for (int v = 0; v < 256; v++) begin
                logic [15:0] a;
                load_seg(8'hD0 + 8'(w), 8'(v));
                a = 16'(w * 16384 + 8192 + (v * 37) % 8192);
                if (v >= 8'hA0)       probe("R3", a, 1'b1, 1'b0);
                else if (v >= 8'h20)  probe("R2", a, 1'b1, 1'b0);
                else                  probe("R4", a, 1'b1, 1'b0);
                if (v < 8'h20)        probe("R5", a, 1'b0, 1'b1);
                else if (v < 8'hA0)   probe("R2", a, 1'b0, 1'b1);
                else                  probe("R3", a, 1'b0, 1'b1);
                if (w == 0) begin
                    ovl_ram = 1'b1;
                    probe("R7", a, 1'b1, 1'b0);
                    ovl_ram = 1'b0;
                end
                probe("R1", 16'(((w + 1) % 4) * 16384 + 16'h2abc), 1'b1, 1'b0);
            end
        end

        // R6: overlay independent of segment register 0
        foreach (shadow[k]) begin end
        for (int v = 0; v < 256; v += 17) begin
            load_seg(8'hD0, 8'(v));
            ovl_ram = 1'b0;
            probe("R6", 16'h1FFF, 1'b1, 1'b0);
            probe("R6", 16'h0000, 1'b0, 1'b1);
            ovl_ram = 1'b1;
            probe("R6", 16'h1ABC, 1'b1, 1'b0);
            probe("R6", 16'h0123, 1'b0, 1'b1);
            probe("R7", 16'h2000, 1'b1, 1'b0);
            ovl_ram = 1'b0;
        end

        // R10: foreign ports leave registers unchanged
        load_seg(8'hD0, 8'h05); load_seg(8'hD1, 8'h40);
        load_seg(8'hD2, 8'hA5); load_seg(8'hD3, 8'h9F);
        load_seg(8'hCF, 8'h33); load_seg(8'hD4, 8'h77); load_seg(8'h50, 8'h21);
        for (int w = 0; w < 4; w++) probe("R10", 16'(w * 16384 + 16'h3001), 1'b1, 1'b0);

        // R1: collision of load and access in the same cycle
        @(negedge clk);
        io_wr = 1'b1; io_port = 8'hD1; io_data = 8'h2A;
        cpu_addr = 16'h4567; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        check("R1", {phys_addr, rom_sel, ram_sel, ram_we, unmapped},
              model(8'h40, 16'h4567, 1'b0, 1'b1, 1'b0));
        @(negedge clk);
        io_wr = 1'b0;
        shadow[1] = 8'h2A;
        #1;
        check("R1", {phys_addr, rom_sel, ram_sel, ram_we, unmapped},
              model(8'h2A, 16'h4567, 1'b0, 1'b1, 1'b0));

        // R8: reset again clears all registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
        for (int w = 0; w < 4; w++) probe("R8", 16'(w * 16384 + 16'h3FFF), 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule